// File: doc/BRIEF.md
# UART register and interrupt controller

This block is the software-visible register front end of a serial port. A simple 32-bit bus addresses it by byte offset within a 4 KB window, and each register takes one 32-bit word. The block stores the baud divisors, line and port control, the FIFO level selection, the infrared low-power divisor and the DMA control word. It also keeps the interrupt state and drives one level-sensitive interrupt line. Eight fixed identification bytes sit at the top of the window.

On the data side, a write to the data word hands its low byte to a transmitter through a one-cycle strobe. A read of the data word returns the head of a receive FIFO that lives outside this block. The same read pops that entry in the access cycle. The block watches the FIFO fill level and raises a receive interrupt when the level reaches a threshold that software selects.

Top module: `uart_csr_ctrl`

## Requirements
- R1: After a synchronous reset, every configuration register, the interrupt mask and the raw interrupt status read as zero, and `irq`, `bus_rvalid` and `bus_err` are low.
- R2: Word indices (byte offset >> 2) 8, 9, 10, 11, 12, 13, 14 and 18 are read/write, holding 8, 16, 6, 8, 16, 6, 11 and 3 bits. A read returns the stored bits zero-extended, on `bus_rdata`, with `bus_rvalid` high in the cycle after the read.
- R3: Reads at byte offsets 0xFE0, 0xFE4 … 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R4: A write to index 0 pulses `tx_wr` in the same cycle, with `tx_byte` equal to `bus_wdata[7:0]`, and sets raw status bit 5 (transmit).
- R5: Index 15 reads the raw status and index 16 reads the raw status ANDed with the mask. `irq` is high exactly when that AND is nonzero.
- R6: A write to index 17 clears every raw status bit written as one and leaves all other bits unchanged.
- R7: A read of index 0 with a nonempty FIFO asserts `rx_pop` in that cycle and returns `rx_data`. A read of index 0 with an empty FIFO returns zero and does not pop.
- R8: Index 6 reads flags: bit 7 is always 1 (transmit empty) and bit 5 is always 0 (transmit full). Bit 4 is 1 when the FIFO level is zero. Bit 6 is 1 when the level equals the FIFO depth with FIFO mode on (index 11 bit 4), or is nonzero with FIFO mode off.
- R9: The receive threshold is 4*sel+1 with FIFO mode on, where sel is index 13 bits [5:3], and 1 with FIFO mode off. Raw bit 4 is set when the FIFO level rises from below the threshold to or above it. It is cleared when the level falls back below the threshold. A new set wins over a clear in the same cycle.
- R10: A read of an index that is not readable (anything other than 0, 6, 8–16, 18 and the ID words) returns zero. A write of an index that is not writable (anything other than 0, 8–14, 17, 18) changes nothing. Either one raises `bus_err` for one cycle, in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_err | output | 1 | Illegal access pulse, one cycle after |
| tx_wr | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Pop the receive FIFO head |
| rx_data | input | 8 | Receive FIFO head |
| rx_level | input | CNT_W | Receive FIFO fill level |
| irq | output | 1 | Combined interrupt |

## Verification
The results of this block fall due at three distances from a stimulus.
- **Same cycle:** `tx_wr`, `tx_byte` and `rx_pop` follow the access in the same cycle. The bench checks them one time unit after it drives the inputs at the falling edge.
- **Next cycle:** read data, `bus_rvalid` and `bus_err` are registered. They are due one cycle after the access. `irq` changes one cycle after a write to the mask, clear or data word, or one cycle after the level input crosses the threshold. The bench checks all of these at the falling edge after the rising edge that updates them.
- **Receive interrupt after a pop:** the bench's FIFO model applies a pop at that rising edge and presents the new level at the next falling edge. The receive interrupt therefore drops two cycles after the popping read. The behavioural model steps on each rising edge from the same inputs, so its expected values follow the same timing.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IRQ_W   = 11;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int TRIG_W  = 6;

    localparam int TX_BIT      = 5;
    localparam int RX_BIT      = 4;
    localparam int FIFO_EN_BIT = 4;

    typedef enum logic [3:0] {
        REG_DATA, REG_FLAG, REG_ILP, REG_IBD, REG_FBD, REG_LINE, REG_CTRL,
        REG_LVL, REG_MASK, REG_RAW, REG_MST, REG_CLR, REG_DMA, REG_ID, REG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [7:0]  ilp;
        logic [15:0] ibd;
        logic [5:0]  fbd;
        logic [7:0]  line;
        logic [15:0] ctrl;
        logic [5:0]  lvl;
        logic [2:0]  dma;
    } cfg_t;

    function automatic reg_sel_e decode_word(input logic [IDX_W-1:0] idx);
        reg_sel_e r;
        case (idx)
            10'd0:   r = REG_DATA;
            10'd6:   r = REG_FLAG;
            10'd8:   r = REG_ILP;
            10'd9:   r = REG_IBD;
            10'd10:  r = REG_FBD;
            10'd11:  r = REG_LINE;
            10'd12:  r = REG_CTRL;
            10'd13:  r = REG_LVL;
            10'd14:  r = REG_MASK;
            10'd15:  r = REG_RAW;
            10'd16:  r = REG_MST;
            10'd17:  r = REG_CLR;
            10'd18:  r = REG_DMA;
            default: r = (idx[IDX_W-1:3] == '1) ? REG_ID : REG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic can_read(input reg_sel_e r);
        return !(r == REG_CLR || r == REG_NONE);
    endfunction

    function automatic logic can_write(input reg_sel_e r);
        return !(r == REG_FLAG || r == REG_RAW || r == REG_MST ||
                 r == REG_ID || r == REG_NONE);
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0: b = 8'h11;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
    import uart_csr_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          which,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic              bad
);
    always_comb begin
        which  = decode_word(addr[ADDR_W-1:2]);
        rd_hit = sel && !wr && can_read(which);
        wr_hit = sel && wr && can_write(which);
        bad    = sel && (wr ? !can_write(which) : !can_read(which));
    end
endmodule

// File: rtl/uart_csr_cfg.sv
module uart_csr_cfg
    import uart_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  reg_sel_e          which,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg_o,
    output logic [TRIG_W-1:0] trig_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_hit) begin
            case (which)
                REG_ILP:  cfg_q.ilp  <= wdata[7:0];
                REG_IBD:  cfg_q.ibd  <= wdata[15:0];
                REG_FBD:  cfg_q.fbd  <= wdata[5:0];
                REG_LINE: cfg_q.line <= wdata[7:0];
                REG_CTRL: cfg_q.ctrl <= wdata[15:0];
                REG_LVL:  cfg_q.lvl  <= wdata[5:0];
                REG_DMA:  cfg_q.dma  <= wdata[2:0];
                default: ;
            endcase
        end
    end

    // Threshold: level select times four plus one in FIFO mode, else one.
    always_comb begin
        if (cfg_q.line[FIFO_EN_BIT])
            trig_o = {1'b0, cfg_q.lvl[5:3], 2'b00} + TRIG_W'(1);
        else
            trig_o = TRIG_W'(1);
    end

    assign cfg_o = cfg_q;

    // R9
    trig_floor_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o != '0);
endmodule

// File: rtl/uart_csr_intr.sv
module uart_csr_intr
    import uart_csr_pkg::*;
#(
    parameter int CNT_W = 5
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [IRQ_W-1:0]  wdata,
    input  logic              tx_set,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [TRIG_W-1:0] trig,
    output logic [IRQ_W-1:0]  raw_o,
    output logic [IRQ_W-1:0]  mask_o,
    output logic              irq_o
);
    logic [IRQ_W-1:0] raw_q, mask_q, set_v, drop_v;
    logic [CNT_W-1:0] lvl_q;
    logic             above_now, above_prev;

    always_comb begin
        above_now  = int'(rx_level) >= int'(trig);
        above_prev = int'(lvl_q) >= int'(trig);
        set_v  = '0;
        drop_v = clr_we ? wdata : '0;
        set_v[TX_BIT] = tx_set;
        set_v[RX_BIT] = above_now && !above_prev;
        if (!above_now && above_prev)
            drop_v[RX_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
            lvl_q  <= '0;
        end else begin
            raw_q <= (raw_q & ~drop_v) | set_v;
            lvl_q <= rx_level;
            if (mask_we)
                mask_q <= wdata;
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign irq_o  = |(raw_q & mask_q);

    // R4
    tx_raw_chk: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> raw_q[TX_BIT]);
    // R6
    icr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && wdata[TX_BIT] && !tx_set) |=> !raw_q[TX_BIT]);
    // R9
    rx_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (above_now && !above_prev) |=> raw_q[RX_BIT]);
endmodule

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
    import uart_csr_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic              tx_wr,
    output logic [7:0]        tx_byte,
    output logic              rx_pop,
    input  logic [7:0]        rx_data,
    input  logic [CNT_W-1:0]  rx_level,
    output logic              irq
);
    reg_sel_e          which;
    logic              rd_hit, wr_hit, bad;
    cfg_t              cfg;
    logic [TRIG_W-1:0] trig;
    logic [IRQ_W-1:0]  raw, mask;
    logic [7:0]        flags;
    logic              rx_empty, rx_full;
    logic [31:0]       rd_val;
    logic [31:0]       rdata_q;
    logic              rvalid_q, err_q;

    uart_csr_decode u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .which(which), .rd_hit(rd_hit), .wr_hit(wr_hit), .bad(bad)
    );

    uart_csr_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .which(which),
        .wdata(bus_wdata), .cfg_o(cfg), .trig_o(trig)
    );

    uart_csr_intr #(.CNT_W(CNT_W)) u_intr (
        .clk(clk), .rst(rst),
        .mask_we(wr_hit && which == REG_MASK),
        .clr_we(wr_hit && which == REG_CLR),
        .wdata(bus_wdata[IRQ_W-1:0]),
        .tx_set(tx_wr),
        .rx_level(rx_level), .trig(trig),
        .raw_o(raw), .mask_o(mask), .irq_o(irq)
    );

    always_comb begin
        tx_wr    = wr_hit && which == REG_DATA;
        tx_byte  = bus_wdata[7:0];
        rx_empty = rx_level == '0;
        rx_full  = cfg.line[FIFO_EN_BIT] ? (int'(rx_level) == FIFO_DEPTH) : !rx_empty;
        rx_pop   = rd_hit && which == REG_DATA && !rx_empty;
        flags    = 8'h80;
        flags[6] = rx_full;
        flags[4] = rx_empty;
    end

    always_comb begin
        rd_val = '0;
        case (which)
            REG_DATA: rd_val = rx_empty ? 32'd0 : 32'(rx_data);
            REG_FLAG: rd_val = 32'(flags);
            REG_ILP:  rd_val = 32'(cfg.ilp);
            REG_IBD:  rd_val = 32'(cfg.ibd);
            REG_FBD:  rd_val = 32'(cfg.fbd);
            REG_LINE: rd_val = 32'(cfg.line);
            REG_CTRL: rd_val = 32'(cfg.ctrl);
            REG_LVL:  rd_val = 32'(cfg.lvl);
            REG_MASK: rd_val = 32'(mask);
            REG_RAW:  rd_val = 32'(raw);
            REG_MST:  rd_val = 32'(raw & mask);
            REG_DMA:  rd_val = 32'(cfg.dma);
            REG_ID:   rd_val = 32'(id_byte(bus_addr[4:2]));
            default:  rd_val = '0;
        endcase
        if (!rd_hit)
            rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            rdata_q  <= rd_val;
            rvalid_q <= bus_sel && !bus_wr;
            err_q    <= bad;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign bus_err    = err_q;

    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rx_level != '0 && !bus_wr));
    // R10
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel));
    // R2
    rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_sel && !bus_wr));
    // R3
    id_width_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(bus_addr[11:5] == 7'h7F)) |-> bus_rdata[31:8] == '0);
endmodule

// File: tb/uart_csr_ctrl_test.sv
module uart_csr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err, tx_wr, rx_pop, irq;
    logic [7:0]  tx_byte;
    logic [7:0]  rx_data_drv = '0;
    logic [4:0]  rx_level_drv = '0;

    always #5 clk = ~clk;

    uart_csr_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .bus_err(bus_err), .tx_wr(tx_wr),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_data(rx_data_drv),
        .rx_level(rx_level_drv), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";
    byte unsigned q[$];

    int unsigned m_ilp, m_ibd, m_fbd, m_line, m_ctrl, m_lvl, m_mask, m_dma, m_raw;
    int unsigned m_prev;
    int unsigned e_rdata;
    bit e_rvalid, e_err;
    int unsigned ids[8] = '{32'h11, 32'h10, 32'h14, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, tag, act, exp);
        end
    endtask

    // Behavioural model stepped on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_ilp = 0; m_ibd = 0; m_fbd = 0; m_line = 0; m_ctrl = 0; m_lvl = 0;
            m_mask = 0; m_dma = 0; m_raw = 0; m_prev = 0;
            e_rdata = 0; e_rvalid = 0; e_err = 0;
        end else begin
            int unsigned lv, trig, setb, clrb, idx;
            bit legal;
            lv   = rx_level_drv;
            trig = (m_line & 32'h10) != 0 ? ((m_lvl >> 3) & 7) * 4 + 1 : 1;
            setb = 0; clrb = 0;
            if (lv >= trig && m_prev < trig) setb |= 32'h10;
            else if (lv < trig && m_prev >= trig) clrb |= 32'h10;
            m_prev = lv;
            e_rvalid = 0; e_err = 0; e_rdata = 0;
            if (bus_sel) begin
                idx = bus_addr >> 2;
                legal = 1;
                if (!bus_wr) begin
                    e_rvalid = 1;
                    if (idx >= 32'h3F8) e_rdata = ids[idx - 32'h3F8];
                    else case (idx)
                        0: if (lv > 0) begin e_rdata = q[0]; void'(q.pop_front()); end
                        6: e_rdata = 32'h80 | (((m_line & 32'h10) != 0 ? lv == 16 : lv != 0) ? 32'h40 : 0)
                                     | (lv == 0 ? 32'h10 : 0);
                        8: e_rdata = m_ilp;   9: e_rdata = m_ibd;   10: e_rdata = m_fbd;
                        11: e_rdata = m_line; 12: e_rdata = m_ctrl; 13: e_rdata = m_lvl;
                        14: e_rdata = m_mask; 15: e_rdata = m_raw;  16: e_rdata = m_raw & m_mask;
                        18: e_rdata = m_dma;
                        default: legal = 0;
                    endcase
                end else begin
                    case (idx)
                        0: setb |= 32'h20;
                        8: m_ilp = bus_wdata & 32'hFF;
                        9: m_ibd = bus_wdata & 32'hFFFF;
                        10: m_fbd = bus_wdata & 32'h3F;
                        11: m_line = bus_wdata & 32'hFF;
                        12: m_ctrl = bus_wdata & 32'hFFFF;
                        13: m_lvl = bus_wdata & 32'h3F;
                        14: m_mask = bus_wdata & 32'h7FF;
                        17: clrb |= bus_wdata & 32'h7FF;
                        18: m_dma = bus_wdata & 32'h7;
                        default: legal = 0;
                    endcase
                end
                e_err = !legal;
            end
            m_raw = (m_raw & ~clrb) | setb;
        end
    end

    // FIFO model drives its outputs at the falling edge.
    always @(negedge clk) begin
        rx_level_drv <= 5'(q.size());
        rx_data_drv  <= q.size() > 0 ? q[0] : 8'h00;
    end

    // Registered outputs checked at the falling edge; same-cycle ones just after.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(bus_rvalid == e_rvalid, "rvalid", bus_rvalid, e_rvalid);
            if (e_rvalid) chk(bus_rdata == e_rdata, "rdata", bus_rdata, e_rdata);
            chk(bus_err == e_err, "R10 err", bus_err, e_err);
            chk(irq == ((m_raw & m_mask) != 0), "R5 irq", irq, (m_raw & m_mask) != 0);
            #1;
            chk(tx_wr == (bus_sel && bus_wr && bus_addr < 4), "R4 tx_wr", tx_wr, 0);
            if (tx_wr) chk(tx_byte == bus_wdata[7:0], "R4 tx_byte", tx_byte, bus_wdata[7:0]);
            chk(rx_pop == (bus_sel && !bus_wr && bus_addr < 4 && rx_level_drv != 0),
                "R7 pop", rx_pop, 0);
        end
    end

    task automatic acc(input bit w, input int unsigned a, input int unsigned d);
        @(negedge clk);
        bus_sel = 1; bus_wr = w; bus_addr = 12'(a); bus_wdata = d;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic push(input byte unsigned b);
        @(negedge clk);
        bus_sel = 0;
        q.push_back(b);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1 reset values
        cur_req = "R1";
        chk(irq == 0 && bus_rvalid == 0 && bus_err == 0, "R1 outputs", {irq, bus_rvalid, bus_err}, 0);
        for (int i = 8; i <= 18; i++) if (i != 17) acc(0, i * 4, 0);
        idle(2);
        // R2 readback with width masking
        cur_req = "R2";
        for (int i = 8; i <= 14; i++) acc(1, i * 4, 32'hFFFF_FFFF);
        acc(1, 18 * 4, 32'hFFFF_FFFF);
        for (int i = 8; i <= 14; i++) acc(0, i * 4, 0);
        acc(0, 18 * 4, 0);
        acc(1, 9 * 4, 32'h1234_5A5A); acc(1, 12 * 4, 32'h0000_0301); acc(1, 14 * 4, 0);
        acc(1, 11 * 4, 0); acc(1, 13 * 4, 0);
        acc(0, 9 * 4, 0); acc(0, 12 * 4, 0);
        idle(2);
        // R3 identification bytes
        cur_req = "R3";
        for (int i = 0; i < 8; i++) acc(0, 32'hFE0 + i * 4, 0);
        idle(2);
        // R10 illegal accesses
        cur_req = "R10";
        acc(0, 32'h004, 0); acc(0, 32'h01C, 0); acc(0, 32'h044, 0); acc(0, 32'h800, 0);
        acc(1, 32'h018, 32'hFF); acc(1, 32'h03C, 32'h7FF); acc(1, 32'hFE0, 32'hFF);
        acc(1, 32'h004, 32'hFF);
        acc(0, 32'h03C, 0); acc(0, 32'hFE0, 0); acc(0, 32'h018, 0);
        idle(2);
        // R4 transmit write
        cur_req = "R4";
        acc(1, 0, 32'h1A5); acc(1, 0, 32'h3C);
        acc(0, 15 * 4, 0);
        idle(2);
        // R5 mask and masked status
        cur_req = "R5";
        acc(1, 14 * 4, 32'h20); acc(0, 16 * 4, 0);
        acc(1, 14 * 4, 32'h10); acc(0, 16 * 4, 0);
        acc(1, 14 * 4, 32'h30);
        idle(2);
        // R6 clear register
        cur_req = "R6";
        acc(1, 17 * 4, 32'h10); acc(0, 15 * 4, 0);
        acc(1, 17 * 4, 32'h20); acc(0, 15 * 4, 0);
        idle(2);
        // R8 flags
        cur_req = "R8";
        acc(0, 6 * 4, 0);
        push(8'h41); idle(2);
        acc(0, 6 * 4, 0);
        acc(1, 11 * 4, 32'h10);
        for (int i = 1; i < 16; i++) push(8'(8'h41 + i));
        idle(3);
        acc(0, 6 * 4, 0);
        idle(2);
        // R7 data reads pop in order
        cur_req = "R7";
        for (int i = 0; i < 16; i++) acc(0, 0, 0);
        idle(3);
        acc(0, 0, 0); acc(0, 6 * 4, 0);
        idle(3);
        // R9 receive threshold
        cur_req = "R9";
        acc(1, 17 * 4, 32'h7FF);
        acc(1, 13 * 4, 32'h08);
        idle(2);
        for (int i = 0; i < 4; i++) push(8'(i));
        idle(3);
        acc(0, 15 * 4, 0);
        push(8'h55); idle(3);
        acc(0, 15 * 4, 0);
        acc(0, 0, 0); idle(4);
        acc(0, 15 * 4, 0);
        acc(1, 11 * 4, 0); idle(3);
        acc(0, 15 * 4, 0);
        for (int i = 0; i < 4; i++) acc(0, 0, 0);
        idle(4);
        acc(0, 15 * 4, 0);
        idle(3);
        report();
    end
endmodule